// File: doc/BRIEF.md
# ECC Error Log and Interrupt Registers

This block sits next to an ECC-protected on-chip RAM and records the failures that the ECC checker reports. Two kinds of event arrive from the checker: correctable and uncorrectable. Each comes with the RAM offset that failed and the 64-bit word that was read. For each kind the block keeps one log slot. A slot holds the first failure until software acknowledges it, and later failures of the same kind do not overwrite it.

Each log slot is a two-state machine. In `SLOT_EMPTY` the slot has nothing logged, and its status bit reads 0. The transition `capture` (an event arrives while empty) latches the offset and data and moves the slot to `SLOT_HELD`. In `SLOT_HELD` the status bit reads 1. The transition `release` (a write of one to the status bit with no event in the same cycle) returns the slot to `SLOT_EMPTY`. The self-loop `hold` covers a further event, or an event that coincides with a clear: the slot stays in `SLOT_HELD` and the log is not touched. A separate interrupt controller keeps a two-bit mask, which enable and disable writes change. It drives one registered interrupt line that is high while an unmasked slot is held.

Software reaches the block through a simple 32-bit register port with a byte address. Reads are combinational and return the state as it stands after the last clock edge. Writes take effect at the next edge. The block also provides a general control word and an ECC-enable flag that the surrounding logic uses.

Top module: `ecclog_regs`

## Requirements
- R1: After reset the status register (0x04) reads 0, the mask register (0x08) reads 0xC0, the control word (0x00) and the ECC control register (0x14) read 0, all log words read 0, and `irq` is 0.
- R2: A correctable event (`ce_valid`) sets status bit 6. If that bit was clear, the event also latches the offset, zero-extended, at 0x1C, data bits 31:0 at 0x20 and data bits 63:32 at 0x24. All of these are visible after the next clock edge.
- R3: An uncorrectable event (`ue_valid`) sets status bit 7. If that bit was clear, the event also latches the offset at 0x34, data bits 31:0 at 0x38 and data bits 63:32 at 0x3C.
- R4: While a status bit is set, further events of the same kind leave that kind's log words unchanged.
- R5: Writing 0x04 clears each status bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0 unchanged. After a clear, the next event of that kind is captured afresh.
- R6: An event that arrives in the same cycle as a write of one to the same status bit wins: the bit stays set and the held log is kept.
- R7: Writing 1 to bit 6 or bit 7 of the enable register (0x0C) clears that mask bit. Writing 1 to bit 6 or bit 7 of the disable register (0x10) sets it. The enable and disable registers read as 0.
- R8: `irq` equals, one clock edge later, the OR over bits 6 and 7 of the status register with the mask bits applied (a bit counts when its mask bit is 0).
- R9: The ECC control register (0x14) stores bit 0, reads it back and drives `ecc_enable`. The control word (0x00) stores all 32 bits and drives `cfg_ctrl`.
- R10: Reads of unmapped offsets return 0. Writes to the read-only registers (mask and the six log words) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ce_valid | input | 1 | Correctable error event |
| ce_addr | input | 18 | RAM offset of the correctable error |
| ce_data | input | 64 | Failing word of the correctable error |
| ue_valid | input | 1 | Uncorrectable error event |
| ue_addr | input | 18 | RAM offset of the uncorrectable error |
| ue_data | input | 64 | Failing word of the uncorrectable error |
| irq | output | 1 | Registered interrupt request |
| ecc_enable | output | 1 | ECC enable flag from the ECC control register |
| cfg_ctrl | output | 32 | Contents of the control word |

## Verification
Status bits, log words, mask bits and the two configuration registers change at the clock edge that samples the event or write, so they can be read in the cycle after. `irq` trails the status and mask by one further edge. The bench drives every stimulus on the falling edge. It then compares the combinational read data and the outputs against a reference model that it advances only at the rising edge. This places each comparison exactly one edge after its cause, and `irq` is predicted from the model's state before that edge. Directed cases set up the event-versus-clear collision, repeated events and writes to read-only registers. A seeded random phase then mixes events, writes and reads.

// File: rtl/ecclog_pkg.sv
package ecclog_pkg;
    // Byte offsets of the register map
    localparam int OFS_CTRL    = 'h00;
    localparam int OFS_STATUS  = 'h04;
    localparam int OFS_MASK    = 'h08;
    localparam int OFS_ENABLE  = 'h0C;
    localparam int OFS_DISABLE = 'h10;
    localparam int OFS_ECCCTL  = 'h14;
    localparam int OFS_CE_ADDR = 'h1C;
    localparam int OFS_CE_DLO  = 'h20;
    localparam int OFS_CE_DHI  = 'h24;
    localparam int OFS_UE_ADDR = 'h34;
    localparam int OFS_UE_DLO  = 'h38;
    localparam int OFS_UE_DHI  = 'h3C;

    // Event sources: index 0 = correctable, index 1 = uncorrectable
    localparam int NUM_SRC  = 2;
    localparam int SRC_CE   = 0;
    localparam int SRC_UE   = 1;
    localparam int BIT_LO   = 6;            // status bit of source 0
    localparam int BIT_HI   = BIT_LO + NUM_SRC - 1;
    localparam int LOG_DW   = 64;
    localparam int REG_DW   = 32;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;
endpackage

// File: rtl/ecclog_slot.sv
module ecclog_slot
    import ecclog_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = LOG_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] ev_data,
    input  logic              clr,
    output logic              held,
    output logic [ADDR_W-1:0] log_addr,
    output logic [DATA_W-1:0] log_data
);
    slot_state_e state_q, state_d;
    logic        capture;

    // next-state: capture / hold / release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (ev_valid)         state_d = SLOT_HELD;
            SLOT_HELD:  if (clr && !ev_valid) state_d = SLOT_EMPTY;
            default:                          state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    assign capture = (state_q == SLOT_EMPTY) && ev_valid;

    // outputs: log registers written only on the capture transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            log_addr <= '0;
            log_data <= '0;
        end else if (capture) begin
            log_addr <= ev_addr;
            log_data <= ev_data;
        end
    end

    assign held = (state_q == SLOT_HELD);

    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |=> held);
    p_log_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> ($stable(log_addr) && $stable(log_data)));
    p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && clr) |=> held);
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (held && clr && !ev_valid) |=> !held);
endmodule

// File: rtl/ecclog_irqctl.sv
module ecclog_irqctl
    import ecclog_pkg::*;
#(
    parameter int NSRC = NUM_SRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pend,
    input  logic            en_wr,
    input  logic            dis_wr,
    input  logic [NSRC-1:0] wbits,
    output logic [NSRC-1:0] mask,
    output logic            irq
);
    logic [NSRC-1:0] mask_q;
    logic            irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            irq_q  <= 1'b0;
        end else begin
            if (en_wr)       mask_q <= mask_q & ~wbits;
            else if (dis_wr) mask_q <= mask_q | wbits;
            irq_q <= |(pend & ~mask_q);
        end
    end

    assign mask = mask_q;
    assign irq  = irq_q;

    p_enable_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> ((mask & $past(wbits)) == '0));
    p_disable_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dis_wr |=> ((mask & $past(wbits)) == $past(wbits)));
    p_irq_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |=> !irq);
endmodule

// File: rtl/ecclog_regs.sv
module ecclog_regs
    import ecclog_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ce_valid,
    input  logic [ADDR_W-1:0] ce_addr,
    input  logic [63:0]       ce_data,
    input  logic              ue_valid,
    input  logic [ADDR_W-1:0] ue_addr,
    input  logic [63:0]       ue_data,
    output logic              irq,
    output logic              ecc_enable,
    output logic [31:0]       cfg_ctrl
);
    localparam int HALF = LOG_DW / 2;

    logic              ev_v   [NUM_SRC];
    logic [ADDR_W-1:0] ev_a   [NUM_SRC];
    logic [LOG_DW-1:0] ev_d   [NUM_SRC];
    logic [ADDR_W-1:0] lg_a   [NUM_SRC];
    logic [LOG_DW-1:0] lg_d   [NUM_SRC];
    logic [NUM_SRC-1:0] held, mask, wbits, clr;
    logic wr_status, wr_enable, wr_disable, wr_ctrl, wr_eccctl, wr_mask;
    logic [31:0] ctrl_q;
    logic        ecc_q;

    assign ev_v[SRC_CE] = ce_valid;
    assign ev_a[SRC_CE] = ce_addr;
    assign ev_d[SRC_CE] = ce_data;
    assign ev_v[SRC_UE] = ue_valid;
    assign ev_a[SRC_UE] = ue_addr;
    assign ev_d[SRC_UE] = ue_data;

    assign wbits      = reg_wdata[BIT_HI:BIT_LO];
    assign wr_ctrl    = reg_wen && (reg_addr == REG_AW'(OFS_CTRL));
    assign wr_status  = reg_wen && (reg_addr == REG_AW'(OFS_STATUS));
    assign wr_mask    = reg_wen && (reg_addr == REG_AW'(OFS_MASK));
    assign wr_enable  = reg_wen && (reg_addr == REG_AW'(OFS_ENABLE));
    assign wr_disable = reg_wen && (reg_addr == REG_AW'(OFS_DISABLE));
    assign wr_eccctl  = reg_wen && (reg_addr == REG_AW'(OFS_ECCCTL));
    assign clr        = wr_status ? wbits : '0;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
        ecclog_slot #(.ADDR_W(ADDR_W), .DATA_W(LOG_DW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .ev_valid (ev_v[s]),
            .ev_addr  (ev_a[s]),
            .ev_data  (ev_d[s]),
            .clr      (clr[s]),
            .held     (held[s]),
            .log_addr (lg_a[s]),
            .log_data (lg_d[s])
        );
    end

    ecclog_irqctl #(.NSRC(NUM_SRC)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (held),
        .en_wr  (wr_enable),
        .dis_wr (wr_disable),
        .wbits  (wbits),
        .mask   (mask),
        .irq    (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ecc_q  <= 1'b0;
        end else begin
            if (wr_ctrl)   ctrl_q <= reg_wdata;
            if (wr_eccctl) ecc_q  <= reg_wdata[0];
        end
    end

    assign cfg_ctrl   = ctrl_q;
    assign ecc_enable = ecc_q;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_AW'(OFS_CTRL):    reg_rdata = ctrl_q;
            REG_AW'(OFS_STATUS):  reg_rdata[BIT_HI:BIT_LO] = held;
            REG_AW'(OFS_MASK):    reg_rdata[BIT_HI:BIT_LO] = mask;
            REG_AW'(OFS_ECCCTL):  reg_rdata[0] = ecc_q;
            REG_AW'(OFS_CE_ADDR): reg_rdata[ADDR_W-1:0] = lg_a[SRC_CE];
            REG_AW'(OFS_CE_DLO):  reg_rdata = lg_d[SRC_CE][HALF-1:0];
            REG_AW'(OFS_CE_DHI):  reg_rdata = lg_d[SRC_CE][LOG_DW-1:HALF];
            REG_AW'(OFS_UE_ADDR): reg_rdata[ADDR_W-1:0] = lg_a[SRC_UE];
            REG_AW'(OFS_UE_DLO):  reg_rdata = lg_d[SRC_UE][HALF-1:0];
            REG_AW'(OFS_UE_DHI):  reg_rdata = lg_d[SRC_UE][LOG_DW-1:HALF];
            default:              reg_rdata = '0;
        endcase
    end

    p_ecc_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_eccctl |=> (ecc_enable == $past(reg_wdata[0])));
    p_mask_readonly_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> $stable(mask));
endmodule

// File: tb/ecclog_regs_tb.sv
module ecclog_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ce_valid = 1'b0, ue_valid = 1'b0;
    logic [17:0] ce_addr = '0, ue_addr = '0;
    logic [63:0] ce_data = '0, ue_data = '0;
    logic        irq, ecc_enable;
    logic [31:0] cfg_ctrl;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // reference model
    logic [1:0]  m_st, m_mk;
    logic        m_irq, m_ecc;
    logic [31:0] m_ctrl;
    logic [17:0] m_la [2];
    logic [63:0] m_ld [2];

    always #2 clk = ~clk;

    ecclog_regs u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ce_valid(ce_valid), .ce_addr(ce_addr), .ce_data(ce_data),
        .ue_valid(ue_valid), .ue_addr(ue_addr), .ue_data(ue_data),
        .irq(irq), .ecc_enable(ecc_enable), .cfg_ctrl(cfg_ctrl)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mread(logic [7:0] a);
        case (a)
            8'h00: return m_ctrl;
            8'h04: return {24'b0, m_st, 6'b0};
            8'h08: return {24'b0, m_mk, 6'b0};
            8'h14: return {31'b0, m_ecc};
            8'h1C: return {14'b0, m_la[0]};
            8'h20: return m_ld[0][31:0];
            8'h24: return m_ld[0][63:32];
            8'h34: return {14'b0, m_la[1]};
            8'h38: return m_ld[1][31:0];
            8'h3C: return m_ld[1][63:32];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rtag(logic [7:0] a);
        case (a)
            8'h00, 8'h14: return "R9";
            8'h04: return "R5";
            8'h08, 8'h0C, 8'h10: return "R7";
            8'h1C, 8'h20, 8'h24: return "R2";
            8'h34, 8'h38, 8'h3C: return "R3";
            default: return "R10";
        endcase
    endfunction

    task automatic model_reset();
        m_st = '0; m_mk = 2'b11; m_irq = 0; m_ecc = 0; m_ctrl = '0;
        for (int i = 0; i < 2; i++) begin m_la[i] = '0; m_ld[i] = '0; end
    endtask

    task automatic model_edge();
        logic [1:0] clr, ev;
        m_irq = |(m_st & ~m_mk);
        clr = '0;
        if (reg_wen) begin
            case (reg_addr)
                8'h00: m_ctrl = reg_wdata;
                8'h04: clr = reg_wdata[7:6];
                8'h0C: m_mk = m_mk & ~reg_wdata[7:6];
                8'h10: m_mk = m_mk | reg_wdata[7:6];
                8'h14: m_ecc = reg_wdata[0];
                default: ;
            endcase
        end
        ev = {ue_valid, ce_valid};
        if (ce_valid && !m_st[0]) begin m_la[0] = ce_addr; m_ld[0] = ce_data; end
        if (ue_valid && !m_st[1]) begin m_la[1] = ue_addr; m_ld[1] = ue_data; end
        m_st = ev | (m_st & ~clr);
    endtask

    // one cycle: drive on falling edge, check reads/outputs, advance at rising edge
    task automatic cyc(string tag, logic [7:0] a, logic w = 0, logic [31:0] wd = 0,
                       logic cv = 0, logic [17:0] ca = 0, logic [63:0] cd = 0,
                       logic uv = 0, logic [17:0] ua = 0, logic [63:0] ud = 0);
        @(negedge clk);
        reg_addr = a; reg_wen = w; reg_wdata = wd;
        ce_valid = cv; ce_addr = ca; ce_data = cd;
        ue_valid = uv; ue_addr = ua; ue_data = ud;
        #1;
        chk({tag, " rdata"}, reg_rdata, mread(a));
        chk("R8 irq", {31'b0, irq}, {31'b0, m_irq});
        chk("R9 ecc_enable", {31'b0, ecc_enable}, {31'b0, m_ecc});
        chk("R9 cfg_ctrl", cfg_ctrl, m_ctrl);
        @(posedge clk);
        model_edge();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] alist [14];
        void'($urandom(32'h5EED_0042));
        alist = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h1C,
                  8'h20, 8'h24, 8'h34, 8'h38, 8'h3C, 8'h44, 8'h18};
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset values
        foreach (alist[i]) cyc("R1", alist[i]);

        // R2 correctable capture
        cyc("R2", 8'h04, 0, 0, 1, 18'h2_3456, 64'hDEAD_BEEF_0123_4567);
        cyc("R2", 8'h1C); cyc("R2", 8'h20); cyc("R2", 8'h24);
        // R4 second correctable does not overwrite
        cyc("R4", 8'h20, 0, 0, 1, 18'h0_0011, 64'h1111_2222_3333_4444);
        cyc("R4", 8'h1C); cyc("R4", 8'h24);
        // R3 uncorrectable capture
        cyc("R3", 8'h04, 0, 0, 0, 0, 0, 1, 18'h3_FFFF, 64'hCAFE_F00D_8765_4321);
        cyc("R3", 8'h34); cyc("R3", 8'h38); cyc("R3", 8'h3C);
        // R7 unmask correctable; R8 irq follows one edge later
        cyc("R7", 8'h0C, 1, 32'h0000_0040);
        cyc("R7", 8'h08); cyc("R8", 8'h08); cyc("R8", 8'h04);
        // R5 write zero keeps, write one clears, then fresh capture
        cyc("R5", 8'h04, 1, 32'h0000_0000);
        cyc("R5", 8'h04, 1, 32'h0000_0040);
        cyc("R5", 8'h04); cyc("R5", 8'h04);
        cyc("R5", 8'h1C, 0, 0, 1, 18'h0_0ABC, 64'h0F0F_0F0F_F0F0_F0F0);
        cyc("R5", 8'h1C); cyc("R5", 8'h24);
        // R6 event coincides with clear of the same bit
        cyc("R6", 8'h04, 1, 32'h0000_0080, 0, 0, 0, 1, 18'h0_0005, 64'h5);
        cyc("R6", 8'h04); cyc("R6", 8'h34); cyc("R6", 8'h38);
        // R7 disable and unmask uncorrectable
        cyc("R7", 8'h10, 1, 32'h0000_00C0); cyc("R7", 8'h08);
        cyc("R7", 8'h0C, 1, 32'h0000_0080); cyc("R7", 8'h08);
        cyc("R7", 8'h0C); cyc("R8", 8'h10);
        // R9 configuration registers
        cyc("R9", 8'h14, 1, 32'hFFFF_FFFF); cyc("R9", 8'h14);
        cyc("R9", 8'h00, 1, 32'hA5A5_5A5A); cyc("R9", 8'h00);
        cyc("R9", 8'h14, 1, 32'h0000_0002); cyc("R9", 8'h14);
        // R10 read-only and unmapped
        cyc("R10", 8'h08, 1, 32'h0000_0000); cyc("R10", 8'h08);
        cyc("R10", 8'h1C, 1, 32'h0000_1234); cyc("R10", 8'h1C);
        cyc("R10", 8'h3C, 1, 32'hFFFF_FFFF); cyc("R10", 8'h3C);
        cyc("R10", 8'h44, 1, 32'hFFFF_FFFF); cyc("R10", 8'h44);
        cyc("R10", 8'hFC);

        // constrained random phase
        for (int n = 0; n < 3000; n++) begin
            logic [7:0]  a;
            logic        w, cv, uv;
            logic [31:0] wd;
            a  = alist[$urandom_range(13, 0)];
            w  = ($urandom_range(3, 0) == 0);
            wd = $urandom();
            if ($urandom_range(1, 0) == 1) wd = wd & 32'h0000_00C0;
            cv = ($urandom_range(7, 0) == 0);
            uv = ($urandom_range(9, 0) == 0);
            cyc(rtag(a), a, w, wd, cv, 18'($urandom()), {$urandom(), $urandom()},
                uv, 18'($urandom()), {$urandom(), $urandom()});
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule